// File: doc/BRIEF.md
# Statistics Counter Bank with Snapshot Capture

This block keeps a bank of event counters for a MAC: a couple of byte-volume counters plus frame and error counters. Each counter has a one-cycle pulse input. A byte-volume counter adds the byte count presented with its pulse, and every other counter adds one. Software talks to the bank over a small 16-bit register bus. It reads the bank through a snapshot copy, so that all counters it reads were taken in the same clock cycle.

A write to the control register can do two things. It can copy every live counter into the snapshot storage, and it can zero every live counter, or do both at once. The counters are 40 bits wide, and software reads each one as three 16-bit words. When a counter wraps, it sets a sticky rollover flag. Software reads these flags in groups of sixteen and clears them by reading them. An interrupt line reports flags that software has unmasked. The masks reset to zero, so no interrupt is raised until software programs them.

Top module: `stat_bank`

## Requirements
- R1: Counter i reads through snapshot words at addresses 0x10+3i (bits 15:0), 0x11+3i (bits 31:16) and 0x12+3i (bits 39:32 in read bits 7:0, read bits 15:8 always zero).
- R2: Counters with index below NUM_OCT (default 2) add the ev_bytes value on each pulse. All other counters add exactly one per pulse, whatever ev_bytes carries.
- R3: Writing address 0x00 with bit 0 set copies every live counter, as it stood before that cycle's events, into the snapshot. Live counters keep counting after a snap, and a later snap replaces the earlier copy.
- R4: Writing address 0x00 with bit 1 set zeroes every live counter. A pulse that arrives in the same cycle is discarded.
- R5: When bits 0 and 1 are written together, the snapshot receives the pre-clear values and the live counters become zero.
- R6: When a counter wraps past its maximum, rollover flag i is set: bit i%16 of the flag word at address 0x01+i/16, for four words at 0x01..0x04.
- R7: Reading a flag word returns its value and then clears it. A flag being set in the same cycle as that read stays set.
- R8: Four mask words at 0x05..0x08 can be read and written. irq is high while any flag is set and its mask bit is one. Masks reset to zero.
- R9: After reset, all counters, snapshots, flags and masks are zero, rdata is zero and irq is low.
- R10: Read data appears on bus_rdata after the clock edge that samples bus_rd and holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | NUM_CNT | One-cycle event pulse per counter |
| ev_bytes | input | BYTE_W | Byte count added by the byte-volume counters |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Unmasked rollover indication |

## Verification
Three pairs of actions can fall on the same clock edge. A control write that both snaps and clears must leave the pre-clear value in the snapshot and zero in the live counter. A clear that meets an event pulse must drop the event. A flag-word read that meets a counter wrap must return the old zero and leave the new flag set. The bench drives each pair onto the same negative-edge setup, so that both actions are sampled by one rising edge. It then judges the outcome through later snapshot reads and flag reads, not through internal state. A counter narrowed to 18 bits reaches its wrap in a few events.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int WORD_W     = 16;
  localparam int NUM_FWORD  = 4;
  localparam int FLAG_W     = WORD_W * NUM_FWORD;
  localparam int A_CTRL     = 0;
  localparam int A_ROLL0    = 1;
  localparam int A_MASK0    = 5;
  localparam int A_CNT_BASE = 16;
  localparam int CTRL_SNAP  = 0;
  localparam int CTRL_CLEAR = 1;

  // address of slice s (0 low, 1 mid, 2 upper) of counter i
  function automatic int cnt_addr(input int i, input int s);
    return A_CNT_BASE + 3 * i + s;
  endfunction

  // pick one 16-bit read word out of a zero-extended counter value
  function automatic logic [WORD_W-1:0] slice_word(input logic [47:0] v, input int s);
    logic [WORD_W-1:0] w;
    case (s)
      0:       w = v[15:0];
      1:       w = v[31:16];
      default: w = {8'h00, v[39:32]};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W  = 40,
  parameter int BYTE_W = 14,
  parameter bit IS_OCT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [BYTE_W-1:0] bytes,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  logic [CNT_W:0] inc;
  logic [CNT_W:0] sum;

  generate
    if (IS_OCT) begin : g_oct
      assign inc = {{(CNT_W + 1 - BYTE_W){1'b0}}, bytes};
    end else begin : g_frm
      logic unused_bytes;
      assign unused_bytes = ^bytes;
      assign inc = {{CNT_W{1'b0}}, 1'b1};
    end
  endgenerate

  assign sum  = {1'b0, cnt} + inc;
  assign wrap = ev && !clr && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ev)  cnt <= sum[CNT_W-1:0];
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ev) |=> $stable(cnt));
endmodule

// File: rtl/stat_rollover.sv
module stat_rollover #(
  parameter int NUM_CNT = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CNT-1:0]            set_vec,
  input  logic [stat_pkg::NUM_FWORD-1:0] clr_word,
  output logic [stat_pkg::FLAG_W-1:0]   flags
);
  import stat_pkg::*;
  logic [NUM_CNT-1:0] flag_q;

  generate
    for (genvar b = 0; b < NUM_CNT; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q[b] <= 1'b0;
        else        flag_q[b] <= set_vec[b] | (flag_q[b] & ~clr_word[b / WORD_W]);
      end

      assert_roll_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> flag_q[b]);
      assert_roll_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_word[b / WORD_W] && !set_vec[b]) |=> !flag_q[b]);
    end
  endgenerate

  assign flags = FLAG_W'(flag_q);
endmodule

// File: rtl/stat_regfile.sv
module stat_regfile #(
  parameter int NUM_CNT = 24,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [stat_pkg::WORD_W-1:0]    bus_wdata,
  input  logic [NUM_CNT*CNT_W-1:0]       live_flat,
  input  logic [stat_pkg::FLAG_W-1:0]    flags,
  output logic                           snap_go,
  output logic                           clr_go,
  output logic [stat_pkg::NUM_FWORD-1:0] rd_roll_word,
  output logic [stat_pkg::FLAG_W-1:0]    mask_flat,
  output logic [stat_pkg::WORD_W-1:0]    bus_rdata
);
  import stat_pkg::*;
  localparam int SNAP_W = NUM_CNT * CNT_W;

  logic [SNAP_W-1:0] snap_flat;
  logic [WORD_W-1:0] mask_q [NUM_FWORD];
  logic [WORD_W-1:0] rd_mux;
  logic              ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign snap_go = ctrl_wr && bus_wdata[CTRL_SNAP];
  assign clr_go  = ctrl_wr && bus_wdata[CTRL_CLEAR];

  generate
    for (genvar k = 0; k < NUM_FWORD; k++) begin : g_word
      assign rd_roll_word[k] = bus_rd && (bus_addr == ADDR_W'(A_ROLL0 + k));
      assign mask_flat[k*WORD_W +: WORD_W] = mask_q[k];
      always_ff @(posedge clk) begin
        if (!rst_n) mask_q[k] <= '0;
        else if (bus_wr && (bus_addr == ADDR_W'(A_MASK0 + k))) mask_q[k] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_flat <= '0;
    else if (snap_go) snap_flat <= live_flat;
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_FWORD; k++) begin
      if (bus_addr == ADDR_W'(A_ROLL0 + k)) rd_mux = flags[k*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(A_MASK0 + k)) rd_mux = mask_q[k];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      for (int s = 0; s < 3; s++) begin
        if (bus_addr == ADDR_W'(cnt_addr(i, s)))
          rd_mux = slice_word(48'(snap_flat[i*CNT_W +: CNT_W]), s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_snap_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_go |=> (snap_flat == $past(live_flat)));
  assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(snap_flat));
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int NUM_CNT = 24,
  parameter int NUM_OCT = 2,
  parameter int CNT_W   = 40,
  parameter int BYTE_W  = 14,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] ev_pulse,
  input  logic [BYTE_W-1:0]  ev_bytes,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               irq
);
  import stat_pkg::*;

  logic [NUM_CNT*CNT_W-1:0] live_flat;
  logic [NUM_CNT-1:0]       wrap_vec;
  logic [FLAG_W-1:0]        flags;
  logic [FLAG_W-1:0]        mask_flat;
  logic [NUM_FWORD-1:0]     rd_roll_word;
  logic                     snap_go;
  logic                     clr_go;

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      stat_counter #(
        .CNT_W (CNT_W),
        .BYTE_W(BYTE_W),
        .IS_OCT(i < NUM_OCT)
      ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev_pulse[i]),
        .bytes(ev_bytes),
        .clr  (clr_go),
        .cnt  (live_flat[i*CNT_W +: CNT_W]),
        .wrap (wrap_vec[i])
      );
    end
  endgenerate

  stat_rollover #(.NUM_CNT(NUM_CNT)) u_roll (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (wrap_vec),
    .clr_word(rd_roll_word),
    .flags   (flags)
  );

  stat_regfile #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .live_flat   (live_flat),
    .flags       (flags),
    .snap_go     (snap_go),
    .clr_go      (clr_go),
    .rd_roll_word(rd_roll_word),
    .mask_flat   (mask_flat),
    .bus_rdata   (bus_rdata)
  );

  assign irq = |(flags & mask_flat);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |-> !irq);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

// File: tb/sim_stat_bank.sv
module sim_stat_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] ev_pulse = '0;
  logic [15:0] ev_bytes = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  stat_bank u0 (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ev_bytes(ev_bytes[13:0]),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata0), .irq(irq0)
  );

  stat_bank #(.CNT_W(18), .BYTE_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ev_bytes(ev_bytes),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1), .irq(irq1)
  );

  localparam int NV = 6;
  localparam int    V_IDX [NV] = '{0, 1, 5, 23, 0, 12};
  localparam int    V_N   [NV] = '{3, 2, 7, 1, 5, 10};
  localparam int    V_BYT [NV] = '{1500, 9600, 0, 100, 16383, 7};
  localparam longint V_EXP [NV] = '{4500, 19200, 7, 1, 81915, 10};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d0, output logic [15:0] d1);
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d0 = rdata0; d1 = rdata1;
  endtask

  task automatic rd_cnt(input int i, output longint v0, output longint v1, output logic [15:0] up0);
    logic [15:0] a0, a1, b0, b1, c0, c1;
    rd(16 + 3 * i, a0, a1);
    rd(17 + 3 * i, b0, b1);
    rd(18 + 3 * i, c0, c1);
    v0 = longint'({c0, b0, a0});
    v1 = longint'({c1, b1, a1});
    up0 = c0;
  endtask

  task automatic pulse(input int idx, input int n, input int b);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev_pulse = 24'(1) << idx; ev_bytes = 16'(b);
    end
    @(negedge clk);
    ev_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d0, d1, up0;
    longint v0, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check(rdata0 == 0, "R9 rdata", rdata0, 0);
    check(irq0 == 0, "R9 irq", irq0, 0);
    rd_cnt(0, v0, v1, up0);
    check(v0 == 0, "R9 counter", v0, 0);
    rd(1, d0, d1);
    check(d0 == 0, "R9 flags", d0, 0);
    rd(5, d0, d1);
    check(d0 == 0, "R9 mask", d0, 0);

    // R1 R2: vector table
    for (int v = 0; v < NV; v++) begin
      wr(0, 2);
      pulse(V_IDX[v], V_N[v], V_BYT[v]);
      wr(0, 1);
      rd_cnt(V_IDX[v], v0, v1, up0);
      check(v0 == V_EXP[v], "R2 count", v0, V_EXP[v]);
      check(up0[15:8] == 0, "R1 upper word", longint'(up0), 0);
    end

    // R3 counting continues after snap; later snap overwrites
    wr(0, 2);
    pulse(7, 3, 0);
    wr(0, 1);
    pulse(7, 2, 0);
    rd_cnt(7, v0, v1, up0);
    check(v0 == 3, "R3 snapshot held", v0, 3);
    wr(0, 1);
    rd_cnt(7, v0, v1, up0);
    check(v0 == 5, "R3 second snap", v0, 5);

    // R4 clear coinciding with an event
    pulse(3, 2, 0);
    @(negedge clk);
    ev_pulse = 24'(1) << 3; bus_addr = 8'd0; bus_wdata = 16'd2; bus_wr = 1'b1;
    @(negedge clk);
    ev_pulse = '0; bus_wr = 1'b0;
    wr(0, 1);
    rd_cnt(3, v0, v1, up0);
    check(v0 == 0, "R4 event during clear dropped", v0, 0);

    // R5 snap and clear together
    pulse(9, 4, 0);
    wr(0, 3);
    rd_cnt(9, v0, v1, up0);
    check(v0 == 4, "R5 pre-clear snapshot", v0, 4);
    wr(0, 1);
    rd_cnt(9, v0, v1, up0);
    check(v0 == 0, "R5 live cleared", v0, 0);

    // R6 R1 wrap on the 18-bit instance
    wr(0, 2);
    pulse(0, 4, 16'hFFFF);
    wr(0, 1);
    rd_cnt(0, v0, v1, up0);
    check(v1 == 64'h3FFFC, "R1 slices 18-bit", v1, 64'h3FFFC);
    rd(1, d0, d1);
    check(d1 == 0, "R6 no flag before wrap", d1, 0);
    pulse(0, 1, 16'hFFFF);
    check(irq1 == 0, "R8 masked irq", irq1, 0);
    wr(5, 1);
    check(irq1 == 1, "R8 unmasked irq", irq1, 1);
    check(irq0 == 0, "R8 no flag no irq", irq0, 0);
    rd(5, d0, d1);
    check(d1 == 1, "R8 mask readback", d1, 1);
    rd(1, d0, d1);
    check(d1 == 16'h0001, "R6 flag bit0 word0", d1, 1);
    check(irq1 == 0, "R7 irq after read", irq1, 0);
    rd(1, d0, d1);
    check(d1 == 0, "R7 clear on read", d1, 0);
    wr(0, 1);
    rd_cnt(0, v0, v1, up0);
    check(v1 == 65531, "R6 wrapped value", v1, 65531);

    // R7 wrap in the same cycle as a flag read
    pulse(0, 3, 16'hFFFF);
    @(negedge clk);
    ev_pulse = 24'(1); ev_bytes = 16'hFFFF; bus_addr = 8'd1; bus_rd = 1'b1;
    @(negedge clk);
    ev_pulse = '0; bus_rd = 1'b0;
    check(rdata1 == 0, "R7 read during wrap", rdata1, 0);
    rd(1, d0, d1);
    check(d1 == 1, "R7 set beats clear", d1, 1);

    // R10 unmapped address and hold
    rd(5, d0, d1);
    check(d1 == 1, "R10 read data", d1, 1);
    repeat (2) @(negedge clk);
    check(rdata1 == 1, "R10 hold", rdata1, 1);
    rd(15, d0, d1);
    check(d1 == 0, "R10 unmapped", d1, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule